// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small register file that sits on a simple synchronous register bus and gathers a handful of housekeeping controls: an 8-bit configuration register, an 8-bit diagnostic scratch register, an 8-bit modem-control register, two 8-bit auxiliary registers, a 16-bit LED register and a 32-bit system-control word. A bus access names one register through a select code, gives a byte offset inside that register's window, a 4-bit byte-enable and a write strobe. Data travels right-aligned on a 32-bit bus, and read data is combinational in the same cycle as the access.

The block watches a power-fail input through a short synchronizer. When the configuration register enables it, a change of that input to high sets a power-fail status flag, which drives a level interrupt. Software can clear the flag through the second auxiliary register and can request power-off through the same register. A write to the first auxiliary register can fire a one-cycle terminal-count strobe. A write to the system-control word can request a system reset, and the word records this in a flag that survives reset.

Select codes: 0 configuration, 1 diagnostic, 2 modem, 3 auxiliary 1, 4 auxiliary 2, 5 LED, 6 system control; 7 is unused.

Top module: `aux_sysctl`

## Requirements
- R1: While reset is high and after it falls, the configuration, modem, auxiliary 1, auxiliary 2 (power-fail status included) and LED registers read 0, and irq, tc_pulse, poweroff_req and sysrst_req are low.
- R2: The diagnostic register and the system-control word keep their values through reset.
- R3: An access is valid only with offset 0 and an exact byte-enable: 4'b0001 for codes 0 to 4, 4'b0011 for the LED register, 4'b1111 for the system-control word. Any other access, and any access to code 7, changes nothing, fires no strobe and reads 0.
- R4: irq is high only while the power-fail status (auxiliary 2 bit 5) and the enable (configuration bit 3) are both set.
- R5: When the synchronized power-fail input changes to high while configuration bit 3 is set, status bit 5 becomes 1 on the edge PF_SYNC_STAGES+1 clocks after the input is sampled; status clears once the input is low or bit 3 is 0, and a rise while bit 3 is 0 leaves it clear.
- R6: A write to auxiliary 2 keeps only write-data bits 0 and 1, preserves status bit 5, and bit 1 always reads back 0.
- R7: A write to auxiliary 2 with bit 1 set clears status bit 5 and irq on that edge, and the status stays clear until the input falls and rises again.
- R8: A write to auxiliary 2 with bit 0 set stores bit 0 and raises poweroff_req for exactly one cycle after the write edge; no further pulse comes without another such write.
- R9: A write to auxiliary 1 with bit 1 set raises tc_pulse for exactly one cycle after the write edge; the other seven bits are stored and bit 1 reads back 0.
- R10: A write of the system-control word with bit 0 set makes it read 32'h2 and raises sysrst_req for one cycle; a write with bit 0 clear changes nothing.
- R11: The configuration, diagnostic, modem and LED registers read back the last valid value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_sel | input | 3 | Register select code |
| bus_off | input | 2 | Byte offset inside the register window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, 0 when not a valid read |
| pwr_fail_in | input | 1 | Asynchronous power-fail indication |
| irq | output | 1 | Power-fail interrupt level |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |
| poweroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with PF_SYNC_STAGES set to 3 rather than the default 2, so the power-fail latency it checks is four clock edges and the cycle before the flag appears is checked as well. This depth exposes an off-by-one in the synchronizer chain or in the change detector. The other widths keep their package values, which puts every select code, including the unused one, and every byte-enable pattern in reach.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int SEL_W  = 3;
    localparam int OFF_W  = 2;
    localparam int BE_W   = 4;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int LED_W  = 16;
    localparam int NREG   = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG   = 3'd0,
        SEL_DIAG  = 3'd1,
        SEL_MODEM = 3'd2,
        SEL_AUX1  = 3'd3,
        SEL_AUX2  = 3'd4,
        SEL_LED   = 3'd5,
        SEL_SYS   = 3'd6
    } reg_sel_e;

    localparam int CFG_PF_EN_BIT = 3;
    localparam int AUX1_TC_BIT   = 1;
    localparam int AUX2_OFF_BIT  = 0;
    localparam int AUX2_CLR_BIT  = 1;
    localparam int AUX2_PF_BIT   = 5;
    localparam int SYS_RST_BIT   = 0;
    localparam int SYS_STAT_BIT  = 1;

    typedef struct packed {
        logic tc;
        logic poweroff;
        logic sysrst;
    } pulse_t;

    function automatic logic [BE_W-1:0] lane_mask(input logic [SEL_W-1:0] sel);
        case (sel)
            SEL_CFG, SEL_DIAG, SEL_MODEM, SEL_AUX1, SEL_AUX2: lane_mask = 4'b0001;
            SEL_LED: lane_mask = 4'b0011;
            SEL_SYS: lane_mask = 4'b1111;
            default: lane_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode
    import aux_sysctl_pkg::*;
(
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [OFF_W-1:0] bus_off,
    input  logic [BE_W-1:0]  bus_be,
    output logic [NREG-1:0]  wr_hit,
    output logic [NREG-1:0]  rd_hit
);
    logic [BE_W-1:0] need;
    logic            ok;

    assign need = lane_mask(bus_sel);
    assign ok   = bus_en && (bus_off == '0) && (need != '0) && (bus_be == need);

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = ok &&  bus_wr && (bus_sel == SEL_W'(g));
        assign rd_hit[g] = ok && !bus_wr && (bus_sel == SEL_W'(g));
    end
endmodule

// File: rtl/aux_sysctl_pwrfail.sv
module aux_sysctl_pwrfail #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pf_in,
    input  logic enable,
    input  logic clr,
    output logic status
);
    logic pf_s;
    logic pf_prev;
    logic change;

    if (SYNC_STAGES <= 1) begin : g_one
        logic s_q;
        always_ff @(posedge clk) begin
            if (rst) s_q <= 1'b0;
            else     s_q <= pf_in;
        end
        assign pf_s = s_q;
    end else begin : g_chain
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[SYNC_STAGES-2:0], pf_in};
        end
        assign pf_s = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) pf_prev <= 1'b0;
        else     pf_prev <= pf_s;
    end

    assign change = pf_s != pf_prev;

    always_ff @(posedge clk) begin
        if (rst)                   status <= 1'b0;
        else if (clr)              status <= 1'b0;
        else if (change)           status <= pf_s && enable;
        else if (!enable || !pf_s) status <= 1'b0;
    end
endmodule

// File: rtl/aux_sysctl.sv
module aux_sysctl
    import aux_sysctl_pkg::*;
#(
    parameter int PF_SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_fail_in,
    output logic              irq,
    output logic              tc_pulse,
    output logic              poweroff_req,
    output logic              sysrst_req
);
    logic [NREG-1:0]   wr_hit;
    logic [NREG-1:0]   rd_hit;
    logic [BYTE_W-1:0] cfg_q;
    logic [BYTE_W-1:0] diag_q;
    logic [BYTE_W-1:0] modem_q;
    logic [BYTE_W-1:0] aux1_q;
    logic              aux2_off_q;
    logic [LED_W-1:0]  led_q;
    logic              sys_stat_q;
    logic              pf_status;
    logic              pf_clr;
    pulse_t            pulse_d;
    pulse_t            pulse_q;

    aux_sysctl_decode u_decode (
        .bus_en (bus_en),
        .bus_wr (bus_wr),
        .bus_sel(bus_sel),
        .bus_off(bus_off),
        .bus_be (bus_be),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    assign pf_clr = wr_hit[SEL_AUX2] && bus_wdata[AUX2_CLR_BIT];

    aux_sysctl_pwrfail #(.SYNC_STAGES(PF_SYNC_STAGES)) u_pwrfail (
        .clk   (clk),
        .rst   (rst),
        .pf_in (pwr_fail_in),
        .enable(cfg_q[CFG_PF_EN_BIT]),
        .clr   (pf_clr),
        .status(pf_status)
    );

    // Registers cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            modem_q    <= '0;
            aux1_q     <= '0;
            aux2_off_q <= 1'b0;
            led_q      <= '0;
        end else begin
            if (wr_hit[SEL_CFG])   cfg_q   <= bus_wdata[BYTE_W-1:0];
            if (wr_hit[SEL_MODEM]) modem_q <= bus_wdata[BYTE_W-1:0];
            if (wr_hit[SEL_AUX1]) begin
                aux1_q              <= bus_wdata[BYTE_W-1:0];
                aux1_q[AUX1_TC_BIT] <= 1'b0;
            end
            if (wr_hit[SEL_AUX2])  aux2_off_q <= bus_wdata[AUX2_OFF_BIT];
            if (wr_hit[SEL_LED])   led_q      <= bus_wdata[LED_W-1:0];
        end
    end

    // Registers that keep their contents through reset
    always_ff @(posedge clk) begin
        if (wr_hit[SEL_DIAG]) diag_q <= bus_wdata[BYTE_W-1:0];
        if (wr_hit[SEL_SYS] && bus_wdata[SYS_RST_BIT]) sys_stat_q <= 1'b1;
    end

    always_comb begin
        pulse_d.tc       = wr_hit[SEL_AUX1] && bus_wdata[AUX1_TC_BIT];
        pulse_d.poweroff = wr_hit[SEL_AUX2] && bus_wdata[AUX2_OFF_BIT];
        pulse_d.sysrst   = wr_hit[SEL_SYS]  && bus_wdata[SYS_RST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= pulse_d;
    end

    assign tc_pulse     = pulse_q.tc;
    assign poweroff_req = pulse_q.poweroff;
    assign sysrst_req   = pulse_q.sysrst;
    assign irq          = pf_status && cfg_q[CFG_PF_EN_BIT];

    always_comb begin
        bus_rdata = '0;
        if (rd_hit[SEL_CFG])   bus_rdata[BYTE_W-1:0] = cfg_q;
        if (rd_hit[SEL_DIAG])  bus_rdata[BYTE_W-1:0] = diag_q;
        if (rd_hit[SEL_MODEM]) bus_rdata[BYTE_W-1:0] = modem_q;
        if (rd_hit[SEL_AUX1])  bus_rdata[BYTE_W-1:0] = aux1_q;
        if (rd_hit[SEL_AUX2]) begin
            bus_rdata[AUX2_OFF_BIT] = aux2_off_q;
            bus_rdata[AUX2_PF_BIT]  = pf_status;
        end
        if (rd_hit[SEL_LED])   bus_rdata[LED_W-1:0]    = led_q;
        if (rd_hit[SEL_SYS])   bus_rdata[SYS_STAT_BIT] = sys_stat_q;
    end
endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
    import aux_sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [SEL_W-1:0]  bus_sel,
    input logic [OFF_W-1:0]  bus_off,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              tc_pulse,
    input logic              poweroff_req,
    input logic              sysrst_req,
    input logic [BYTE_W-1:0] cfg_q,
    input logic              pf_status
);
    logic good;
    assign good = (bus_off == '0) && (lane_mask(bus_sel) != '0) && (bus_be == lane_mask(bus_sel));

    AST_BAD_ACCESS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && !good) |-> (bus_rdata == '0)); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cfg_q[CFG_PF_EN_BIT] && pf_status)); // R4
    AST_STATUS_RISE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_status) |-> $past(cfg_q[CFG_PF_EN_BIT])); // R5
    AST_TC_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> $past(bus_en && bus_wr && good && bus_sel == SEL_AUX1 && bus_wdata[AUX1_TC_BIT])); // R9
    AST_POWEROFF_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        poweroff_req |-> $past(bus_en && bus_wr && good && bus_sel == SEL_AUX2 && bus_wdata[AUX2_OFF_BIT])); // R8
    AST_SYSRST_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sysrst_req |-> $past(bus_en && bus_wr && good && bus_sel == SEL_SYS && bus_wdata[SYS_RST_BIT])); // R10
    AST_AUX1_TC_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && good && bus_sel == SEL_AUX1) |-> !bus_rdata[AUX1_TC_BIT]); // R9
    AST_AUX2_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && good && bus_sel == SEL_AUX2 && bus_wdata[AUX2_CLR_BIT]) |=> !irq); // R7
endmodule

bind aux_sysctl aux_sysctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_off     (bus_off),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq         (irq),
    .tc_pulse    (tc_pulse),
    .poweroff_req(poweroff_req),
    .sysrst_req  (sysrst_req),
    .cfg_q       (cfg_q),
    .pf_status   (pf_status)
);

// File: tb/aux_sysctl_tb.sv
module aux_sysctl_tb;
    localparam int SYNC = 3;
    localparam int NV   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [1:0]  bus_off = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwr_fail_in = 1'b0;
    logic        irq, tc_pulse, poweroff_req, sysrst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    aux_sysctl #(.PF_SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_off(bus_off), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_fail_in(pwr_fail_in), .irq(irq), .tc_pulse(tc_pulse),
        .poweroff_req(poweroff_req), .sysrst_req(sysrst_req)
    );

    always #2 clk = ~clk;

    // write then read-back table: select, byte enables, data, expected read
    localparam logic [2:0]  T_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd3, 3'd4, 3'd4, 3'd0};
    localparam logic [3:0]  T_BE  [NV] = '{4'h1, 4'h1, 4'h1, 4'h3, 4'h1, 4'h1, 4'h1, 4'h1};
    localparam logic [31:0] T_WD  [NV] = '{32'hA5, 32'h3C, 32'h81, 32'hBEEF, 32'hFF, 32'hFF, 32'hFC, 32'h00};
    localparam logic [31:0] T_EXP [NV] = '{32'hA5, 32'h3C, 32'h81, 32'hBEEF, 32'hFD, 32'h01, 32'h00, 32'h00};
    localparam string       T_REQ [NV] = '{"R11", "R11", "R11", "R11", "R9", "R6", "R6", "R11"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [3:0] be, input logic [31:0] d,
                      input logic [1:0] off = 2'd0);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_sel = sel; bus_be = be; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [3:0] be, output logic [31:0] d,
                      input logic [1:0] off = 2'd0);
        bus_en = 1'b1; bus_wr = 1'b0; bus_sel = sel; bus_be = be; bus_off = off;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic outs(input string req, input logic [3:0] exp);
        check(req, {28'd0, irq, tc_pulse, poweroff_req, sysrst_req}, {28'd0, exp});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        outs("R1 outputs in reset", 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        rd(3'd0, 4'h1, v); check("R1 cfg", v, 0);
        rd(3'd2, 4'h1, v); check("R1 modem", v, 0);
        rd(3'd3, 4'h1, v); check("R1 aux1", v, 0);
        rd(3'd4, 4'h1, v); check("R1 aux2", v, 0);
        rd(3'd5, 4'h3, v); check("R1 led", v, 0);
        outs("R1 outputs after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            wr(T_SEL[i], T_BE[i], T_WD[i]);
            rd(T_SEL[i], T_BE[i], v);
            check(T_REQ[i], v, T_EXP[i]);
        end

        // R9 terminal-count strobe
        wr(3'd3, 4'h1, 32'h02);
        outs("R9 tc high one cycle", 4'b0100);
        @(negedge clk);
        outs("R9 tc back low", 4'b0000);

        // R8 power-off strobe
        wr(3'd4, 4'h1, 32'h01);
        outs("R8 poweroff high", 4'b0010);
        @(negedge clk);
        outs("R8 poweroff low", 4'b0000);
        repeat (3) @(negedge clk);
        outs("R8 no repeat", 4'b0000);
        rd(3'd4, 4'h1, v); check("R8 bit0 stored", v, 32'h01);

        // R3 mismatched accesses
        wr(3'd0, 4'h1, 32'h11);
        wr(3'd0, 4'h3, 32'h22);
        rd(3'd0, 4'h1, v); check("R3 cfg bad width write ignored", v, 32'h11);
        rd(3'd0, 4'hF, v); check("R3 cfg bad width read", v, 0);
        wr(3'd5, 4'h3, 32'h1234, 2'd2);
        rd(3'd5, 4'h3, v); check("R3 led offset write ignored", v, 32'hBEEF);
        rd(3'd5, 4'h3, v, 2'd2); check("R3 led offset read", v, 0);
        rd(3'd7, 4'h1, v); check("R3 unused select", v, 0);
        wr(3'd6, 4'h1, 32'h01);
        outs("R3 sys bad width no strobe", 4'b0000);
        wr(3'd0, 4'h1, 32'h00);

        // R10 system control
        wr(3'd6, 4'hF, 32'h0);
        outs("R10 no bit0 no strobe", 4'b0000);
        wr(3'd6, 4'hF, 32'h1);
        outs("R10 sysrst high", 4'b0001);
        @(negedge clk);
        outs("R10 sysrst low", 4'b0000);
        rd(3'd6, 4'hF, v); check("R10 status word", v, 32'h2);

        // R2 retention through reset
        wr(3'd1, 4'h1, 32'h5A);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(3'd1, 4'h1, v); check("R2 diag kept", v, 32'h5A);
        rd(3'd6, 4'hF, v); check("R2 sys kept", v, 32'h2);
        rd(3'd5, 4'h3, v); check("R1 led cleared", v, 0);

        // R5 rise while disabled leaves status clear
        pwr_fail_in = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
        rd(3'd4, 4'h1, v); check("R5 disabled no status", v, 0);
        outs("R4 no irq when disabled", 4'b0000);
        pwr_fail_in = 1'b0;
        repeat (SYNC + 3) @(negedge clk);

        // R5 latency with enable set
        wr(3'd0, 4'h1, 32'h08);
        pwr_fail_in = 1'b1;
        repeat (SYNC) @(negedge clk);
        outs("R5 not yet", 4'b0000);
        @(negedge clk);
        outs("R4 R5 irq set", 4'b1000);
        rd(3'd4, 4'h1, v); check("R5 status bit5", v, 32'h20);

        // R6 status preserved across write
        wr(3'd4, 4'h1, 32'hFD);
        rd(3'd4, 4'h1, v); check("R6 merge status", v, 32'h21);
        @(negedge clk);

        // R7 clear
        wr(3'd4, 4'h1, 32'h02);
        outs("R7 irq cleared", 4'b0000);
        repeat (SYNC + 3) @(negedge clk);
        rd(3'd4, 4'h1, v); check("R7 stays clear", v, 0);
        pwr_fail_in = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        pwr_fail_in = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
        outs("R7 sets again", 4'b1000);

        // R5 clears on enable removal
        wr(3'd0, 4'h1, 32'h00);
        @(negedge clk);
        rd(3'd4, 4'h1, v); check("R5 cleared by enable", v, 0);

        // R5 clears on input low
        wr(3'd0, 4'h1, 32'h08);
        pwr_fail_in = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        pwr_fail_in = 1'b1;
        repeat (SYNC + 3) @(negedge clk);
        outs("R5 set again", 4'b1000);
        pwr_fail_in = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        outs("R5 cleared by input low", 4'b0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule